// File: doc/BRIEF.md
# ChaCha20 Block Keystream Generator

This block turns a 256-bit key, a 32-bit block counter and a 96-bit nonce into one 512-bit ChaCha20 keystream block. It holds the cipher state as sixteen 32-bit words. Four quarter-round units work side by side, so a whole round (column or diagonal) is applied to the state on every clock. When the rounds are done, the starting state is added back word by word and the sum is offered as the output block.

A caller presents its inputs with `startValid` and waits for `startReady`; the result comes back with `blockValid` and is held until `blockReady` takes it. Only one block is in flight at a time. A new job is accepted only when the core is idle and its last result has been consumed. Running the core with counter 0 gives the block that serves as the one-time authenticator key. Payload encryption uses the blocks from counter 1 on.

Top module: `chacha_block_core`

## Requirements
- R1: The starting state is: words 0..3 hold 0x61707865, 0x3320646e, 0x79622d32, 0x6b206574; word 4+k holds `keyIn[32k+31:32k]` for k = 0..7; word 12 holds `counterIn`; word 13+n holds `nonceIn[32n+31:32n]` for n = 0..2.
- R2: One quarter round maps (a,b,c,d) by: a+=b, d^=a, d rotl 16; c+=d, b^=c, b rotl 12; a+=b, d^=a, d rotl 8; c+=d, b^=c, b rotl 7. All arithmetic is modulo 2^32.
- R3: NUM_ROUNDS rounds (default 20) are applied, one per clock. Rounds 0,2,4,… act on the column groups (g, g+4, g+8, g+12). Rounds 1,3,5,… act on the diagonal groups (0,5,10,15), (1,6,11,12), (2,7,8,13), (3,4,9,14).
- R4: Output word w, found at `blockOut[32w+31:32w]`, equals the round result word w plus starting word w, modulo 2^32.
- R5: `blockValid` rises at the clock edge NUM_ROUNDS+1 edges after the edge that accepts a start.
- R6: `startReady` is high only when no job is running and no result is pending. A `startValid` seen while `startReady` is low has no effect.
- R7: While `blockValid` is high and `blockReady` is low, `blockValid` stays high and `blockOut` does not change.
- R8: The edge where `blockValid` and `blockReady` are both high clears `blockValid` and raises `startReady`.
- R9: After reset, `blockValid` is low and `startReady` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| startValid | input | 1 | Start request carrying key, counter and nonce |
| startReady | output | 1 | Core can accept a start |
| keyIn | input | 256 | Key, eight 32-bit words, word 0 in the low bits |
| counterIn | input | 32 | Block counter |
| nonceIn | input | 96 | Nonce, three 32-bit words, word 0 in the low bits |
| blockValid | output | 1 | Keystream block is available |
| blockReady | input | 1 | Consumer takes the block |
| blockOut | output | 512 | Keystream block, word 0 in the low bits |

## Verification
The bench runs a published block-function vector and an independent software model over several key, counter and nonce patterns. A wrong word placement, a swapped rotation, or a diagonal group that is off by one would corrupt every output word. Counter 0 and all-ones inputs catch carry and wraparound mistakes in the final addition. The bench counts cycles from acceptance to `blockValid`, so a missing or extra round stage shows as a latency error and as a wrong block. It also drives `startValid` while a result is being held back: a core that accepted that start would overwrite the pending block or later deliver a second block nobody asked for.

// File: rtl/chacha_pkg.sv
package chacha_pkg;
  localparam int WORD_W    = 32;
  localparam int NUM_WORDS = 16;
  localparam int NUM_QR    = 4;
  localparam int KEY_WORDS = 8;
  localparam int NONCE_WORDS = 3;
  localparam int STATE_W   = WORD_W * NUM_WORDS;

  typedef logic [WORD_W-1:0] word_t;
  typedef word_t [NUM_WORDS-1:0] state_t;

  localparam word_t SIGMA0 = 32'h61707865;
  localparam word_t SIGMA1 = 32'h3320646e;
  localparam word_t SIGMA2 = 32'h79622d32;
  localparam word_t SIGMA3 = 32'h6b206574;

  // strobes from control to datapath
  typedef struct packed {
    logic load;
    logic step;
    logic oddRound;
    logic finish;
  } ctl_t;
endpackage

// File: rtl/chacha_qr.sv
module chacha_qr
  import chacha_pkg::*;
(
  input  word_t aIn,
  input  word_t bIn,
  input  word_t cIn,
  input  word_t dIn,
  output word_t aOut,
  output word_t bOut,
  output word_t cOut,
  output word_t dOut
);
  function automatic word_t rotl(input word_t v, input int n);
    return (v << n) | (v >> (WORD_W - n));
  endfunction

  word_t a1, b1, c1, d1, a2, d2;

  always_comb begin
    a1   = aIn + bIn;
    d1   = rotl(dIn ^ a1, 16);
    c1   = cIn + d1;
    b1   = rotl(bIn ^ c1, 12);
    a2   = a1 + b1;
    d2   = rotl(d1 ^ a2, 8);
    cOut = c1 + d2;
    bOut = rotl(b1 ^ cOut, 7);
    aOut = a2;
    dOut = d2;
  end
endmodule

// File: rtl/chacha_ctrl.sv
module chacha_ctrl
  import chacha_pkg::*;
#(
  parameter int NUM_ROUNDS = 20
) (
  input  logic clk,
  input  logic rstN,
  input  logic startValid,
  output logic startReady,
  output logic blockValid,
  input  logic blockReady,
  output ctl_t ctl
);
  localparam int CNT_W = (NUM_ROUNDS > 1) ? $clog2(NUM_ROUNDS) : 1;
  localparam logic [CNT_W-1:0] LAST_RND = CNT_W'(NUM_ROUNDS - 1);

  typedef enum logic [1:0] {ST_IDLE, ST_RUN, ST_FIN, ST_DONE} phase_t;

  phase_t phaseQ, phaseD;
  logic [CNT_W-1:0] roundQ;
  logic accept;

  assign startReady = (phaseQ == ST_IDLE);
  assign blockValid = (phaseQ == ST_DONE);
  assign accept     = startValid && startReady;

  always_comb begin
    phaseD = phaseQ;
    unique case (phaseQ)
      ST_IDLE: if (accept) phaseD = ST_RUN;
      ST_RUN:  if (roundQ == LAST_RND) phaseD = ST_FIN;
      ST_FIN:  phaseD = ST_DONE;
      ST_DONE: if (blockReady) phaseD = ST_IDLE;
      default: phaseD = ST_IDLE;
    endcase
  end

  always_comb begin
    ctl.load     = accept;
    ctl.step     = (phaseQ == ST_RUN);
    ctl.oddRound = roundQ[0];
    ctl.finish   = (phaseQ == ST_FIN);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phaseQ <= ST_IDLE;
      roundQ <= '0;
    end else begin
      phaseQ <= phaseD;
      if (accept)               roundQ <= '0;
      else if (phaseQ == ST_RUN) roundQ <= roundQ + 1'b1;
    end
  end
endmodule

// File: rtl/chacha_dp.sv
module chacha_dp
  import chacha_pkg::*;
(
  input  logic                        clk,
  input  logic                        rstN,
  input  ctl_t                        ctl,
  input  logic [KEY_WORDS*WORD_W-1:0]   keyIn,
  input  word_t                       counterIn,
  input  logic [NONCE_WORDS*WORD_W-1:0] nonceIn,
  output logic [STATE_W-1:0]          blockOut
);
  state_t initVec, workQ, origQ, outQ, roundNext;
  word_t qa [NUM_QR];
  word_t qb [NUM_QR];
  word_t qc [NUM_QR];
  word_t qd [NUM_QR];

  always_comb begin
    initVec[0] = SIGMA0;
    initVec[1] = SIGMA1;
    initVec[2] = SIGMA2;
    initVec[3] = SIGMA3;
    for (int k = 0; k < KEY_WORDS; k++)   initVec[4+k]  = keyIn[WORD_W*k +: WORD_W];
    initVec[12] = counterIn;
    for (int n = 0; n < NONCE_WORDS; n++) initVec[13+n] = nonceIn[WORD_W*n +: WORD_W];
  end

  // one quarter-round lane per group; diagonal lane g shifts rows by g+1..g+3
  for (genvar g = 0; g < NUM_QR; g++) begin : g_lane
    localparam int IB_COL = g + 4;
    localparam int IC_COL = g + 8;
    localparam int ID_COL = g + 12;
    localparam int IB_DIA = 4 + ((g + 1) % 4);
    localparam int IC_DIA = 8 + ((g + 2) % 4);
    localparam int ID_DIA = 12 + ((g + 3) % 4);

    word_t bSel, cSel, dSel;
    assign bSel = ctl.oddRound ? workQ[IB_DIA] : workQ[IB_COL];
    assign cSel = ctl.oddRound ? workQ[IC_DIA] : workQ[IC_COL];
    assign dSel = ctl.oddRound ? workQ[ID_DIA] : workQ[ID_COL];

    chacha_qr u_qr (
      .aIn (workQ[g]),
      .bIn (bSel),
      .cIn (cSel),
      .dIn (dSel),
      .aOut(qa[g]),
      .bOut(qb[g]),
      .cOut(qc[g]),
      .dOut(qd[g])
    );
  end

  always_comb begin
    roundNext = workQ;
    for (int g = 0; g < NUM_QR; g++) begin
      roundNext[g] = qa[g];
      if (ctl.oddRound) begin
        roundNext[4 + ((g + 1) % 4)]  = qb[g];
        roundNext[8 + ((g + 2) % 4)]  = qc[g];
        roundNext[12 + ((g + 3) % 4)] = qd[g];
      end else begin
        roundNext[g + 4]  = qb[g];
        roundNext[g + 8]  = qc[g];
        roundNext[g + 12] = qd[g];
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      workQ <= '0;
      origQ <= '0;
      outQ  <= '0;
    end else begin
      if (ctl.load) begin
        workQ <= initVec;
        origQ <= initVec;
      end else if (ctl.step) begin
        workQ <= roundNext;
      end
      if (ctl.finish) begin
        for (int w = 0; w < NUM_WORDS; w++) outQ[w] <= workQ[w] + origQ[w];
      end
    end
  end

  assign blockOut = outQ;
endmodule

// File: rtl/chacha_block_core.sv
module chacha_block_core
  import chacha_pkg::*;
#(
  parameter int NUM_ROUNDS = 20
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         startValid,
  output logic         startReady,
  input  logic [255:0] keyIn,
  input  logic [31:0]  counterIn,
  input  logic [95:0]  nonceIn,
  output logic         blockValid,
  input  logic         blockReady,
  output logic [511:0] blockOut
);
  ctl_t ctl;

  chacha_ctrl #(.NUM_ROUNDS(NUM_ROUNDS)) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .startValid(startValid),
    .startReady(startReady),
    .blockValid(blockValid),
    .blockReady(blockReady),
    .ctl       (ctl)
  );

  chacha_dp u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .ctl      (ctl),
    .keyIn    (keyIn),
    .counterIn(counterIn),
    .nonceIn  (nonceIn),
    .blockOut (blockOut)
  );
endmodule

// File: rtl/chacha_block_core_chk.sv
module chacha_block_core_chk #(
  parameter int NUM_ROUNDS = 20
) (
  input logic         clk,
  input logic         rstN,
  input logic         startValid,
  input logic         startReady,
  input logic         blockValid,
  input logic         blockReady,
  input logic [511:0] blockOut
);
  logic [15:0] latCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                         latCnt <= '0;
    else if (startValid && startReady) latCnt <= '0;
    else if (latCnt != 16'hFFFF)       latCnt <= latCnt + 16'd1;
  end

  // R6
  ready_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    startReady |-> !blockValid);

  // R6
  accept_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    (startValid && startReady) |=> (!startReady && !blockValid));

  // R5
  latency_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(blockValid) |-> (latCnt == 16'(NUM_ROUNDS + 1)));

  // R7
  hold_out_chk: assert property (@(posedge clk) disable iff (!rstN)
    (blockValid && !blockReady) |=> (blockValid && $stable(blockOut)));

  // R8
  release_chk: assert property (@(posedge clk) disable iff (!rstN)
    (blockValid && blockReady) |=> (startReady && !blockValid));
endmodule

bind chacha_block_core chacha_block_core_chk #(.NUM_ROUNDS(NUM_ROUNDS)) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .startValid(startValid),
  .startReady(startReady),
  .blockValid(blockValid),
  .blockReady(blockReady),
  .blockOut  (blockOut)
);

// File: tb/chacha_block_core_tb.sv
module chacha_block_core_tb;
  localparam int NR = 20;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         startValid = 1'b0;
  logic         startReady;
  logic [255:0] keyIn = '0;
  logic [31:0]  counterIn = '0;
  logic [95:0]  nonceIn = '0;
  logic         blockValid;
  logic         blockReady = 1'b0;
  logic [511:0] blockOut;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  chacha_block_core #(.NUM_ROUNDS(NR)) u_dut (
    .clk(clk), .rstN(rstN), .startValid(startValid), .startReady(startReady),
    .keyIn(keyIn), .counterIn(counterIn), .nonceIn(nonceIn),
    .blockValid(blockValid), .blockReady(blockReady), .blockOut(blockOut)
  );

  task automatic check(input bit ok, input string req, input logic [511:0] act, input logic [511:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // independent model built from R1..R4
  function automatic logic [31:0] rl(input logic [31:0] v, input int n);
    return (v << n) | (v >> (32 - n));
  endfunction

  function automatic logic [127:0] qrf(input logic [31:0] a, b, c, d);
    a = a + b; d = rl(d ^ a, 16);
    c = c + d; b = rl(b ^ c, 12);
    a = a + b; d = rl(d ^ a, 8);
    c = c + d; b = rl(b ^ c, 7);
    return {a, b, c, d};
  endfunction

  function automatic logic [511:0] refBlock(input logic [255:0] k, input logic [31:0] ctr, input logic [95:0] n);
    logic [31:0] s [16];
    logic [31:0] x [16];
    logic [511:0] r;
    s[0] = 32'h61707865; s[1] = 32'h3320646e; s[2] = 32'h79622d32; s[3] = 32'h6b206574;
    for (int i = 0; i < 8; i++) s[4+i] = k[32*i +: 32];
    s[12] = ctr;
    for (int i = 0; i < 3; i++) s[13+i] = n[32*i +: 32];
    x = s;
    for (int r2 = 0; r2 < NR / 2; r2++) begin
      {x[0], x[4], x[8],  x[12]} = qrf(x[0], x[4], x[8],  x[12]);
      {x[1], x[5], x[9],  x[13]} = qrf(x[1], x[5], x[9],  x[13]);
      {x[2], x[6], x[10], x[14]} = qrf(x[2], x[6], x[10], x[14]);
      {x[3], x[7], x[11], x[15]} = qrf(x[3], x[7], x[11], x[15]);
      {x[0], x[5], x[10], x[15]} = qrf(x[0], x[5], x[10], x[15]);
      {x[1], x[6], x[11], x[12]} = qrf(x[1], x[6], x[11], x[12]);
      {x[2], x[7], x[8],  x[13]} = qrf(x[2], x[7], x[8],  x[13]);
      {x[3], x[4], x[9],  x[14]} = qrf(x[3], x[4], x[9],  x[14]);
    end
    for (int i = 0; i < 16; i++) r[32*i +: 32] = x[i] + s[i];
    return r;
  endfunction

  // start one job, return latency in cycles and leave the result pending
  task automatic launch(input logic [255:0] k, input logic [31:0] ctr, input logic [95:0] n, output int lat);
    @(negedge clk);
    while (!startReady) @(negedge clk);
    keyIn = k; counterIn = ctr; nonceIn = n; startValid = 1'b1;
    @(negedge clk);
    startValid = 1'b0;
    lat = 0;
    while (!blockValid && lat < 200) begin
      @(negedge clk);
      lat++;
    end
  endtask

  task automatic take();
    blockReady = 1'b1;
    @(negedge clk);
    blockReady = 1'b0;
  endtask

  task automatic t_reset();
    @(negedge clk);
    check(blockValid == 1'b0, "R9 blockValid", 512'(blockValid), 512'd0);
    check(startReady == 1'b1, "R9 startReady", 512'(startReady), 512'd1);
  endtask

  task automatic t_rfc();
    logic [255:0] k;
    logic [511:0] exp;
    int lat;
    for (int i = 0; i < 32; i++) k[8*i +: 8] = 8'(i);
    exp = {32'h4e3c50a2, 32'he883d0cb, 32'hb94e16de, 32'hd19c12b5,
           32'ha2028bd9, 32'h05d7c214, 32'h09aa9f07, 32'h466482d2,
           32'h4e6cd4c3, 32'h9aaa2204, 32'h0368c033, 32'hc7f4d1c7,
           32'hc47120a3, 32'h1fdd0f50, 32'h15593bd1, 32'he4e7f110};
    launch(k, 32'd1, {32'h00000000, 32'h4a000000, 32'h09000000}, lat);
    // R1 R2 R3 R4: published vector
    check(blockOut == exp, "R1 R2 R3 R4 vector", blockOut, exp);
    // R5
    check(lat == NR + 1, "R5 latency", 512'(lat), 512'(NR + 1));
    take();
    // R8
    check(startReady && !blockValid, "R8 release", 512'({startReady, blockValid}), 512'b10);
  endtask

  task automatic t_patterns();
    logic [255:0] k;
    logic [31:0] c;
    logic [95:0] n;
    logic [511:0] exp;
    int lat;
    for (int p = 0; p < 6; p++) begin
      case (p)
        0: begin k = '0; c = 32'd0; n = '0; end
        1: begin k = '1; c = 32'hFFFF_FFFF; n = '1; end
        2: begin k = {8{32'h8000_0001}}; c = 32'd0; n = {3{32'hDEAD_BEEF}}; end
        default: begin
          for (int i = 0; i < 8; i++) k[32*i +: 32] = $urandom;
          c = $urandom;
          for (int i = 0; i < 3; i++) n[32*i +: 32] = $urandom;
        end
      endcase
      exp = refBlock(k, c, n);
      launch(k, c, n, lat);
      check(blockOut == exp, "R1 R2 R3 R4 model", blockOut, exp);
      check(lat == NR + 1, "R5 latency", 512'(lat), 512'(NR + 1));
      take();
    end
  endtask

  task automatic t_backpressure();
    logic [255:0] k;
    logic [511:0] exp, held;
    int lat;
    k = {8{32'h0123_4567}};
    exp = refBlock(k, 32'd7, 96'h5);
    launch(k, 32'd7, 96'h5, lat);
    held = blockOut;
    // try to start another job while result is pending: must be ignored (R6)
    keyIn = '1; counterIn = 32'd99; nonceIn = '1; startValid = 1'b1;
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      check(startReady == 1'b0, "R6 busy ready", 512'(startReady), 512'd0);
    end
    startValid = 1'b0;
    // R7
    check(blockValid == 1'b1, "R7 valid held", 512'(blockValid), 512'd1);
    check(blockOut == held && held == exp, "R7 data held", blockOut, exp);
    take();
    // R6: no second block must appear
    begin
      bit seen = 1'b0;
      for (int i = 0; i < NR + 6; i++) begin
        @(negedge clk);
        if (blockValid) seen = 1'b1;
      end
      check(!seen, "R6 ignored start", 512'(seen), 512'd0);
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    t_reset();
    t_rfc();
    t_patterns();
    t_backpressure();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule